// File: doc/BRIEF.md
# External Bus Request/Grant Arbiter

This block decides who owns the external memory bus: the processor core or an outside master. The outside master raises a request line that may be asynchronous to the block's clock. The block waits for the point where handing the bus over is safe, which is any cycle with no external access in flight. It then turns off the core's address, data and strobe drivers, raises grant, and either halts the core or lets it keep running. When the request goes away, the bus is returned and the core carries on from the point where it stopped.

The core tells the block when an external access is in flight and when that access completes. The bus is released only between accesses, never in the middle of one. This means the grant can fall between the two external accesses of a single instruction. A run-while-granted mode lets the core keep executing internal work during the grant. In that mode the core stalls only when it reaches an instruction that needs the external bus. A hang indicator reports that the core is waiting for the bus to come back. Arbitration keeps working while the core is held in system reset.

Top module: `xbus_arbiter`

## Requirements
- R1: After `rst_n` is released and before any request, `bus_grant`=0, `drv_en`=1, `core_halt`=0 and `grant_hang`=0.
- R2: `bus_req` passes through a two-flop synchronizer. A change of `bus_req` that is set up before rising edge k is seen on `bus_grant` after edge k+2, and not earlier.
- R3: When the synchronized request is high, the bus is not granted and no access is in flight (`acc_busy`=0), `bus_grant` goes to 1 and `drv_en` goes to 0 after the next edge.
- R4: While `acc_busy`=1 and `acc_done`=0, no grant is given. If the synchronized request is high in the cycle with `acc_done`=1, the grant appears in the following cycle.
- R5: A one-cycle gap with `acc_busy`=0 between two accesses of one instruction is enough for the grant to be inserted.
- R6: `core_halt` = `bus_grant` when `go_mode`=0. When `go_mode`=1, `core_halt` is high only while `bus_grant`=1 and `need_ext`=1.
- R7: `grant_hang` is high exactly while `bus_grant`=1 and `need_ext`=1.
- R8: Once granted, the grant holds while the synchronized request stays high. After it falls, `bus_grant` goes to 0, `drv_en` goes to 1, and `core_halt` and `grant_hang` go to 0 on the next edge.
- R9: While `core_rst`=1, `acc_busy` is ignored and the request is granted as if no access were in flight.
- R10: `bus_grant` and `drv_en` are registered, and in every cycle exactly one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's flops |
| core_rst | input | 1 | Core held in system reset; in-flight access indication ignored |
| bus_req | input | 1 | Bus request from the external master, asynchronous |
| acc_busy | input | 1 | Core external access in progress |
| acc_done | input | 1 | Current external access completes this cycle |
| need_ext | input | 1 | Next core instruction needs the external bus |
| go_mode | input | 1 | 1: core keeps running while the bus is granted |
| bus_grant | output | 1 | Bus granted to the external master |
| drv_en | output | 1 | Enable for the core's address, data and strobe drivers |
| core_halt | output | 1 | Stall the core |
| grant_hang | output | 1 | Core waits for the bus, which is granted away |

## Verification
The bench measures the exact request-to-grant and release latency through the synchronizer. A design that dropped or added a stage would move the grant edge by one cycle. It holds a long access with the request pending, then a one-cycle access gap. A design that ignored the busy flag would yank the bus mid-access, and one that ignored completion would miss the gap between two accesses. It toggles run-while-granted mode and the need-external flag while the bus is granted, which shows whether halt and hang are wrongly tied to grant alone. It also raises the request during system reset, where a design that still honoured the busy flag would never grant.

// File: rtl/xbus_arbiter.sv
module xbus_arbiter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic core_rst,
  input  logic bus_req,
  input  logic acc_busy,
  input  logic acc_done,
  input  logic need_ext,
  input  logic go_mode,
  output logic bus_grant,
  output logic drv_en,
  output logic core_halt,
  output logic grant_hang
);
  logic [SYNC_STAGES-1:0] req_sync;
  logic req_s, busy_live, grant_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) req_sync <= '0;
    else        req_sync <= {req_sync[SYNC_STAGES-2:0], bus_req};

  assign req_s     = req_sync[SYNC_STAGES-1];
  assign busy_live = acc_busy & ~core_rst;
  assign grant_nxt = bus_grant ? req_s : (req_s & (~busy_live | acc_done));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bus_grant <= 1'b0;
      drv_en    <= 1'b1;
    end else begin
      bus_grant <= grant_nxt;
      drv_en    <= ~grant_nxt;
    end

  assign core_halt  = bus_grant & (~go_mode | need_ext);
  assign grant_hang = bus_grant & need_ext;
endmodule

module xbus_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic core_rst,
  input logic req_s,
  input logic acc_busy,
  input logic acc_done,
  input logic need_ext,
  input logic go_mode,
  input logic bus_grant,
  input logic drv_en,
  input logic core_halt,
  input logic grant_hang
);
  // R10
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant != drv_en);
  // R3
  grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_grant && req_s && !acc_busy) |=> bus_grant);
  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_grant && acc_busy && !acc_done && !core_rst) |=> !bus_grant);
  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant && !req_s) |=> (!bus_grant && drv_en));
  // R9
  rst_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_grant && req_s && core_rst) |=> bus_grant);
  // R6
  go_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_mode && !need_ext) |-> !core_halt);
  // R7
  hang_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_hang |-> core_halt);
endmodule

bind xbus_arbiter xbus_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .req_s(req_s),
  .acc_busy(acc_busy), .acc_done(acc_done), .need_ext(need_ext),
  .go_mode(go_mode), .bus_grant(bus_grant), .drv_en(drv_en),
  .core_halt(core_halt), .grant_hang(grant_hang)
);

// File: tb/tb_xbus_arbiter.sv
module tb_xbus_arbiter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic core_rst = 0, bus_req = 0, acc_busy = 0, acc_done = 0, need_ext = 0, go_mode = 0;
  logic bus_grant, drv_en, core_halt, grant_hang;
  int checks = 0, errors = 0, cyc = 0;
  bit auto_on = 0, done_flag = 0;
  string phase = "R3";
  logic m_s1, m_s2, m_g;

  always #10 clk = ~clk;

  xbus_arbiter dut (.*);

  function automatic logic next_grant(logic g, logic rq, logic busy, logic dn, logic crst);
    if (g) return rq;
    return rq & (!(busy & !crst) | dn);
  endfunction
  function automatic logic exp_halt(logic g, logic go, logic ne);
    return g & (go ? ne : 1'b1);
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin m_s1 <= 0; m_s2 <= 0; m_g <= 0; end
    else begin
      m_s1 <= bus_req; m_s2 <= m_s1;
      m_g  <= next_grant(m_g, m_s2, acc_busy, acc_done, core_rst);
    end

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && auto_on) begin
      chk(phase, "grant", bus_grant, m_g);
      chk("R10", "drv_en", drv_en, !m_g);
      chk("R6", "halt", core_halt, exp_halt(m_g, go_mode, need_ext));
      chk("R7", "hang", grant_hang, m_g & need_ext);
    end
    if (cyc > 100000 && !done_flag) begin
      errors++; done_flag = 1;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(int n); repeat (n) @(negedge clk); endtask

  initial begin
    void'($urandom(32'd2024));
    step(3); rst_n = 1; step(1);
    chk("R1", "grant", bus_grant, 0); chk("R1", "drv_en", drv_en, 1);
    chk("R1", "halt", core_halt, 0);  chk("R1", "hang", grant_hang, 0);
    auto_on = 1;
    // R2 R3: latency through synchronizer
    phase = "R2"; bus_req = 1;
    step(1); chk("R2", "grant edge1", bus_grant, 0);
    step(1); chk("R2", "grant edge2", bus_grant, 0);
    step(1); chk("R3", "grant edge3", bus_grant, 1); chk("R3", "drv_en", drv_en, 0);
    chk("R6", "halt go0", core_halt, 1);
    // R8 release
    phase = "R8"; bus_req = 0;
    step(2); chk("R8", "still granted", bus_grant, 1);
    step(1); chk("R8", "released", bus_grant, 0); chk("R8", "drv_en", drv_en, 1);
    chk("R8", "halt", core_halt, 0);
    // R4 request during long access
    phase = "R4"; acc_busy = 1; bus_req = 1;
    step(6); chk("R4", "held off", bus_grant, 0); chk("R4", "drv_en", drv_en, 1);
    acc_done = 1; step(1); acc_done = 0; acc_busy = 0;
    chk("R4", "grant after done", bus_grant, 1);
    bus_req = 0; step(4);
    // R5 gap between two accesses
    phase = "R5"; acc_busy = 1; bus_req = 1; step(4);
    chk("R5", "no grant mid access", bus_grant, 0);
    acc_busy = 0; step(1);
    chk("R5", "grant in gap", bus_grant, 1);
    acc_busy = 1; step(2); chk("R5", "held", bus_grant, 1);
    acc_busy = 0; bus_req = 0; step(4);
    // R6 R7 run-while-granted
    phase = "R6"; go_mode = 1; need_ext = 0; bus_req = 1; step(4);
    chk("R6", "run while granted", core_halt, 0); chk("R7", "no hang", grant_hang, 0);
    need_ext = 1; step(1);
    chk("R6", "halt on ext", core_halt, 1); chk("R7", "hang", grant_hang, 1);
    bus_req = 0; step(3);
    chk("R7", "hang drops", grant_hang, 0); chk("R8", "grant drops", bus_grant, 0);
    need_ext = 0; go_mode = 0; step(2);
    // R9 during core reset
    phase = "R9"; core_rst = 1; acc_busy = 1; bus_req = 1; step(3);
    chk("R9", "grant in reset", bus_grant, 1);
    bus_req = 0; step(4); core_rst = 0; acc_busy = 0; step(2);
    // random mix
    phase = "R3 R4 R5 R8";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 9) == 0) bus_req = ~bus_req;
      acc_busy = ($urandom_range(0, 2) != 0);
      acc_done = acc_busy & ($urandom_range(0, 3) == 0);
      need_ext = $urandom_range(0, 1);
      if ($urandom_range(0, 49) == 0) go_mode = ~go_mode;
      core_rst = ($urandom_range(0, 29) == 0);
      step(1);
    end
    auto_on = 0; done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule